// File: doc/BRIEF.md
# Composite Bus Clock Divider

The block derives a slow timing strobe for a serial bus engine from a fast reference clock. The division ratio is the product of three cascaded stages: a fixed divide-by-four prescaler, a linear stage of length 4·m+1 set by an 8-bit timing value m, and a power-of-two stage of length 2^e set by a 3-bit exponent e. The output is a one-cycle tick per divided period, together with a combinational readback of the divisor that the current fields select.

Software supplies the timing value twice, as a message timing field and as an address timing field. The divider runs only while the two copies agree and the global enable is high. Any other combination stops the chain, returns every stage to zero, and makes the readback report zero. The block samples a new timing value or exponent only at the start of a period, so a reprogramming never produces a shortened or stretched period.

Top module: `bus_tick_divider`

## Requirements
- R1: While running, with timing value m and exponent e, successive ticks are exactly D = 4·(4·m+1)·2^e reference cycles apart.
- R2: When the divider starts running, the cycle of its first edge counts as period state 0, and the first tick appears D−1 cycles later.
- R3: `tick_o` is high for exactly one reference cycle in each period.
- R4: While `run_en_i` is low, `tick_o` stays low and all stage counters are held at zero. After a new enable, the next tick again follows the rule in R2.
- R5: While `msg_time_i` differs from `addr_time_i`, `tick_o` stays low and the counters are held at zero, as in R4. Once the fields match again, the divider restarts as in R2.
- R6: `divisor_o` equals 4·(4·m+1)·2^e when `msg_time_i` equals `addr_time_i`, and 0 otherwise. It does not depend on `run_en_i`.
- R7: The divider samples m and e at the period start, the cycle after a tick. If m or e changes during a period, that period keeps its old length, and the following period uses D for the new values.
- R8: The extreme settings give the expected periods: m=1 with e=0 gives 20 cycles, m=255 with e=0 gives 4084 cycles, and m=1 with e=7 gives 2560 cycles. m=255 with e=7 reads back as 522752.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Global enable for the divided clock |
| msg_time_i | input | 8 | Timing value m, message copy |
| addr_time_i | input | 8 | Timing value m, address copy; must equal the message copy |
| div_exp_i | input | 3 | Power-of-two exponent e |
| tick_o | output | 1 | One-cycle strobe per divided period |
| divisor_o | output | 19 | Effective total divisor, zero when the timing copies differ |

## Verification
The case that is hardest to reach from the ports is a reprogramming that lands mid-period. It must keep the current period at its old length and then move cleanly to the new one. The stimulus waits for a tick and steps three cycles into the next period before it writes a new timing value. It then measures two intervals: the remainder of the running period, which should be D_old−3, and the full period that follows, which should be D_new. The stop paths are covered separately. Dropping the enable or splitting the two timing copies mid-period must silence the tick, and the next start must again take exactly D−1 cycles.

// File: rtl/bus_tick_div_pkg.sv
package bus_tick_div_pkg;
   // fixed prescaler: divide by 2**PRE_LOG2
   localparam int PRE_LOG2 = 2;

   // width of the power-of-two stage counter for an exponent of ew bits
   function automatic int pow2_cnt_width(input int ew);
      int w;
      w = (1 << ew) - 1;
      if (w < 1) w = 1;
      return w;
   endfunction
endpackage

// File: rtl/btd_stage.sv
module btd_stage #(
   parameter int W = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   input  logic         adv_i,
   input  logic [W-1:0] limit_i,
   output logic         zero_o,
   output logic         term_o
);
   logic [W-1:0] cnt_q;

   if (W < 1) begin : g_bad_width
      $error("btd_stage: W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (clear_i)
         cnt_q <= '0;
      else if (adv_i)
         cnt_q <= term_o ? '0 : cnt_q + W'(1);
   end

   assign term_o = (cnt_q == limit_i);
   assign zero_o = (cnt_q == '0);

   // R1
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= limit_i);
endmodule

// File: rtl/btd_readback.sv
module btd_readback #(
   parameter int TW = 8,
   parameter int EW = 3,
   parameter int DW = 19
) (
   input  logic [TW-1:0] m_i,
   input  logic [EW-1:0] e_i,
   input  logic          valid_i,
   output logic [DW-1:0] div_o
);
   import bus_tick_div_pkg::*;

   logic [DW-1:0] lin;

   always_comb begin
      lin   = DW'({m_i, 2'b00}) + DW'(1);
      div_o = valid_i ? (lin << (int'(e_i) + PRE_LOG2)) : '0;
   end
endmodule

// File: rtl/bus_tick_divider.sv
module bus_tick_divider #(
   parameter  int TW = 8,
   parameter  int EW = 3,
   localparam int DW = bus_tick_div_pkg::PRE_LOG2 + TW + 2 + (1 << EW) - 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          run_en_i,
   input  logic [TW-1:0] msg_time_i,
   input  logic [TW-1:0] addr_time_i,
   input  logic [EW-1:0] div_exp_i,
   output logic          tick_o,
   output logic [DW-1:0] divisor_o
);
   import bus_tick_div_pkg::*;

   localparam int LW = TW + 2;
   localparam int PW = pow2_cnt_width(EW);

   if (TW < 1 || TW > 16) begin : g_bad_tw
      $error("bus_tick_divider: TW out of range");
   end
   if (EW < 0 || EW > 4) begin : g_bad_ew
      $error("bus_tick_divider: EW out of range");
   end

   logic          match, run, start;
   logic [TW-1:0] m_sh;
   logic [EW-1:0] e_sh;
   logic          z0, z1, z2, t0, t1, t2;
   logic [LW-1:0] lim1;

   assign match = (msg_time_i == addr_time_i);
   assign run   = run_en_i && match;
   assign start = z0 && z1 && z2;

   // settings are captured only while stopped or in period state 0
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         m_sh <= '0;
         e_sh <= '0;
      end else if (!run || start) begin
         m_sh <= msg_time_i;
         e_sh <= div_exp_i;
      end
   end

   assign lim1 = {m_sh, 2'b00};

   btd_stage #(.W(PRE_LOG2)) i_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!run), .adv_i(run),
      .limit_i({PRE_LOG2{1'b1}}), .zero_o(z0), .term_o(t0));

   btd_stage #(.W(LW)) i_lin (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!run), .adv_i(run && t0),
      .limit_i(lim1), .zero_o(z1), .term_o(t1));

   if (EW > 0) begin : g_pow2
      logic [PW:0]   one_sh;
      logic [PW-1:0] lim2;
      assign one_sh = (PW+1)'(1) << e_sh;
      assign lim2   = PW'(one_sh - (PW+1)'(1));
      btd_stage #(.W(PW)) i_pow (
         .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!run), .adv_i(run && t0 && t1),
         .limit_i(lim2), .zero_o(z2), .term_o(t2));
   end else begin : g_no_pow2
      assign z2 = 1'b1;
      assign t2 = 1'b1;
   end

   assign tick_o = run && t0 && t1 && t2;

   btd_readback #(.TW(TW), .EW(EW), .DW(DW)) i_rb (
      .m_i(msg_time_i), .e_i(div_exp_i), .valid_i(match), .div_o(divisor_o));

   // ---------------- checks ----------------
   logic [DW-1:0] per_cnt, exp_per;

   btd_readback #(.TW(TW), .EW(EW), .DW(DW)) i_rb_sh (
      .m_i(m_sh), .e_i(e_sh), .valid_i(1'b1), .div_o(exp_per));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         per_cnt <= '0;
      else if (!run || tick_o)
         per_cnt <= '0;
      else
         per_cnt <= per_cnt + DW'(1);
   end

   // R1 R2 R7
   period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> per_cnt == exp_per - DW'(1));

   // R3
   single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

   // R4 R5
   restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> !tick_o);
endmodule

// File: tb/test_bus_tick_divider.sv
module test_bus_tick_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  mt = 8'd1, at = 8'd1;
   logic [2:0]  ex = 3'd0;
   logic        tick;
   logic [18:0] dv;
   int          checks = 0, fails = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   bus_tick_divider i_bus_tick_divider (
      .clk_i(clk), .rst_ni(rst_n), .run_en_i(en), .msg_time_i(mt),
      .addr_time_i(at), .div_exp_i(ex), .tick_o(tick), .divisor_o(dv));

   function automatic int dexp(input int m, input int e);
      return 4 * (4 * m + 1) * (1 << e);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   // cycles until tick is seen, -1 after maxc
   task automatic wait_tick(input int maxc, output int n);
      n = -1;
      for (int i = 1; i <= maxc; i++) begin
         @(posedge clk); @(negedge clk);
         if (tick) begin n = i; break; end
      end
   endtask

   task automatic count_ticks(input int cycles, output int k);
      k = 0;
      for (int i = 0; i < cycles; i++) begin
         @(posedge clk); @(negedge clk);
         if (tick) k++;
      end
   endtask

   task automatic set_cfg(input int m, input int e);
      mt = 8'(m); at = 8'(m); ex = 3'(e);
   endtask

   task automatic t_reset;
      int k;
      check("R4 reset tick", int'(tick), 0);
      count_ticks(50, k);
      check("R4 disabled ticks", k, 0);
   endtask

   task automatic t_readback;
      set_cfg(1, 0);   #1 check("R6 m1 e0", int'(dv), 20);
      set_cfg(10, 3);  #1 check("R6 m10 e3", int'(dv), 1312);
      set_cfg(255, 7); #1 check("R8 m255 e7", int'(dv), 522752);
      at = 8'd254;     #1 check("R6 mismatch zero", int'(dv), 0);
      set_cfg(1, 0);   #1;
   endtask

   task automatic t_period(input int m, input int e, input string req);
      int n;
      set_cfg(m, e);
      en = 1'b1;
      wait_tick(dexp(m, e) + 10, n);
      check({req, " first"}, n, dexp(m, e) - 1);
      @(posedge clk); @(negedge clk);
      check("R3 tick one cycle", int'(tick), 0);
      wait_tick(dexp(m, e) + 10, n);
      check({req, " period"}, n + 1, dexp(m, e));
      wait_tick(dexp(m, e) + 10, n);
      check({req, " period2"}, n, dexp(m, e));
      en = 1'b0;
      cyc(2);
   endtask

   task automatic t_disable;
      int n, k;
      set_cfg(3, 2);
      en = 1'b1;
      cyc(100);
      en = 1'b0;
      count_ticks(400, k);
      check("R4 ticks while off", k, 0);
      en = 1'b1;
      wait_tick(400, n);
      check("R4 restart first", n, dexp(3, 2) - 1);
      en = 1'b0;
      cyc(2);
   endtask

   task automatic t_mismatch;
      int n, k;
      set_cfg(2, 1);
      en = 1'b1;
      cyc(30);
      at = 8'd5;
      count_ticks(200, k);
      check("R5 ticks on mismatch", k, 0);
      at = 8'd2;
      wait_tick(200, n);
      check("R5 restart first", n, dexp(2, 1) - 1);
      en = 1'b0;
      cyc(2);
   endtask

   task automatic t_change;
      int n;
      set_cfg(2, 1);
      en = 1'b1;
      wait_tick(200, n);
      cyc(3);
      set_cfg(4, 0);
      wait_tick(200, n);
      check("R7 old period kept", n, dexp(2, 1) - 3);
      wait_tick(200, n);
      check("R7 new period", n, dexp(4, 0));
      cyc(5);
      ex = 3'd2;
      wait_tick(400, n);
      check("R7 exp change old", n, dexp(4, 0) - 5);
      wait_tick(400, n);
      check("R7 exp change new", n, dexp(4, 2));
      en = 1'b0;
      cyc(2);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_period(1, 0, "R8 m1 e0");
      t_period(3, 2, "R1 m3 e2");
      t_period(255, 0, "R8 m255 e0");
      t_period(1, 7, "R8 m1 e7");
      t_disable();
      t_mismatch();
      t_change();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule